// File: doc/BRIEF.md
# USB Endpoint Stall Control

This block decides, for each endpoint of a USB device function, whether the endpoint answers a transaction with a STALL handshake. Each endpoint has two stall sources. The first is a software stall bit in a CPU-visible register. The second is an internal halt bit that the host sets and clears with its SetFeature and ClearFeature (ENDPOINT_HALT) requests. Either source can put an endpoint into the stall state. Only the host can take it out again. While the software bit stays set, the halt bit is forced back on.

A token strobe carries the addressed endpoint number. One clock later the block presents a handshake code: STALL if either stall source is active, otherwise ACK or NAK depending on data readiness. An optional auto-clear mode drops the software bit once a STALL handshake has gone out for that endpoint. In that mode, software can set the bit only by writing 1 after it has read the bit as 0. The packet layer, CRC, serial engine and data buffers lie outside this block.

Top module: `ep_halt_ctrl`

## Requirements
- R1: After `rst_n` is asserted, or after a one-cycle `soft_rst` pulse, the register reads 0x00, every halt bit is clear, and every endpoint answers tokens with ACK or NAK.
- R2: A register read returns the software stall bit of endpoint k at bit position k+1 (endpoint 5 at bit 6). Bits 0 and 7 always read 0, and writing them has no effect.
- R3: With `auto_clr_en`=0, a write loads each endpoint's software bit directly from its register bit, whether that value is 0 or 1.
- R4: `tok_vld` is a strobe carrying endpoint `tok_ep`. One cycle after the strobe, `hs_vld`=1 and `hs_code` carries the handshake: 2'b10 (STALL) if that endpoint's software bit or halt bit is 1. Otherwise `hs_code` is 2'b00 (ACK) when `data_ready`=1 and 2'b01 (NAK) when `data_ready`=0. `hs_vld` is 0 in every cycle that does not follow a strobe.
- R5: A host SetFeature (`host_vld`=1, `host_set`=1) sets the halt bit of `host_ep`. A host ClearFeature (`host_set`=0) clears it when the software bit is 0.
- R6: A STALL handshake sent while the software bit is 1 also sets the halt bit. The endpoint therefore keeps stalling after software clears its bit, until the host sends ClearFeature.
- R7: A ClearFeature for an endpoint whose software bit is 1 leaves its halt bit set. This also holds when the ClearFeature arrives in the same cycle as a token to that endpoint.
- R8: With `auto_clr_en`=1, a STALL handshake for an endpoint whose software bit is 1 clears that bit. The next register read shows the cleared bit.
- R9: With `auto_clr_en`=1, writing 1 sets a software bit only if a read has returned that bit as 0 since the previous write. Writing 0 leaves the bit unchanged.
- R10: Host requests naming endpoint 6 or 7 change no state. Tokens for endpoint 6 or 7 always get ACK or NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| soft_rst | input | 1 | Synchronous function-level reset |
| auto_clr_en | input | 1 | Enables auto-clear of software stall bits |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rd | input | 1 | Register read strobe (arms auto-mode set) |
| cpu_rdata | output | 8 | Register read data (combinational) |
| host_vld | input | 1 | Decoded host halt request valid |
| host_set | input | 1 | 1 = SetFeature, 0 = ClearFeature |
| host_ep | input | 3 | Endpoint named in host request |
| tok_vld | input | 1 | Token received strobe |
| tok_ep | input | 3 | Endpoint addressed by token |
| data_ready | input | 1 | Normal-path readiness (ACK vs NAK) |
| hs_vld | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |

## Verification
The bench writes all 256 register values in direct mode and reads each one back. This separates the live bit positions from the reserved ones. It then steps every endpoint number, including the two that do not exist, through set-by-software, set-by-host, release-by-host and release-by-software orderings. Each of these orderings has a different expected handshake, so together they separate the two stall sources. A same-cycle token and ClearFeature shows whether the forced-on halt bit takes priority over the release. In auto-clear mode, writes with and without a preceding zero read show that the read-before-write arming works, and a token shows that the software bit clears after the STALL handshake.

// File: rtl/ep_halt_pkg.sv
package ep_halt_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_code_e;

  // Handshake choice for one addressed endpoint.
  function automatic hs_code_e hs_pick(input logic stalled, input logic ready);
    if (stalled)    return HS_STALL;
    else if (ready) return HS_ACK;
    else            return HS_NAK;
  endfunction

  // Next value of one endpoint's halt bit.
  // A release lands on the software bit; a set and a stall sent by software both force it on.
  function automatic logic halt_next(input logic cur, input logic set_req,
                                     input logic clr_req, input logic sw_bit,
                                     input logic stall_by_sw);
    logic n;
    n = cur;
    if (clr_req)     n = sw_bit;
    if (set_req)     n = 1'b1;
    if (stall_by_sw) n = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/ep_sw_stall_reg.sv
module ep_sw_stall_reg #(
  parameter int NUM_EP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              auto_clr_en,
  input  logic              wr_en,
  input  logic [NUM_EP-1:0] wr_bits,
  input  logic              rd_en,
  input  logic [NUM_EP-1:0] stall_sent,
  output logic [NUM_EP-1:0] sw_q
);

  logic [NUM_EP-1:0] arm_q;      // bit was read as 0 since the last write
  logic [NUM_EP-1:0] wr_accept;  // named event: write changes this bit
  logic [NUM_EP-1:0] wr_val;

  for (genvar k = 0; k < NUM_EP; k++) begin : g_bit
    always_comb begin
      wr_accept[k] = wr_en && (auto_clr_en ? (wr_bits[k] && arm_q[k]) : 1'b1);
      wr_val[k]    = auto_clr_en ? 1'b1 : wr_bits[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            sw_q[k] <= 1'b0;
      else if (soft_rst)                     sw_q[k] <= 1'b0;
      else if (wr_accept[k])                 sw_q[k] <= wr_val[k];
      else if (auto_clr_en && stall_sent[k]) sw_q[k] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     arm_q[k] <= 1'b0;
      else if (soft_rst)              arm_q[k] <= 1'b0;
      else if (wr_en)                 arm_q[k] <= 1'b0;
      else if (rd_en && !sw_q[k])     arm_q[k] <= 1'b1;
    end

    // R8: stall sent in auto mode drops the software bit
    p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_clr_en && stall_sent[k] && !wr_en && !soft_rst) |=> !sw_q[k]);

    // R9: an unarmed or zero write in auto mode changes nothing
    p_unarmed_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_clr_en && wr_en && !(wr_bits[k] && arm_q[k]) && !stall_sent[k] && !soft_rst)
      |=> sw_q[k] == $past(sw_q[k]));

    // R3: direct mode write lands as written
    p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_clr_en && wr_en && !soft_rst) |=> sw_q[k] == $past(wr_bits[k]));

    // R1: function reset clears the bit
    p_soft_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !sw_q[k]);
  end

endmodule

// File: rtl/ep_halt_track.sv
module ep_halt_track
  import ep_halt_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              host_vld,
  input  logic              host_set,
  input  logic [IDX_W-1:0]  host_ep,
  input  logic [NUM_EP-1:0] sw_q,
  input  logic [NUM_EP-1:0] stall_sent,
  output logic [NUM_EP-1:0] halt_q
);

  logic [NUM_EP-1:0] set_req;  // named event: SetFeature for endpoint k
  logic [NUM_EP-1:0] clr_req;  // named event: ClearFeature for endpoint k

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    always_comb begin
      set_req[k] = host_vld &&  host_set && (host_ep == IDX_W'(k));
      clr_req[k] = host_vld && !host_set && (host_ep == IDX_W'(k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        halt_q[k] <= 1'b0;
      else if (soft_rst) halt_q[k] <= 1'b0;
      else               halt_q[k] <= halt_next(halt_q[k], set_req[k], clr_req[k],
                                                sw_q[k], stall_sent[k]);
    end

    // R5: SetFeature sets halt
    p_set_feature_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req[k] && !soft_rst) |=> halt_q[k]);

    // R5: ClearFeature releases halt when software bit is clear and no stall is sent
    p_clear_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[k] && !sw_q[k] && !stall_sent[k]) |=> !halt_q[k]);

    // R7: ClearFeature cannot release while software bit is set
    p_clear_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[k] && sw_q[k] && !soft_rst) |=> halt_q[k]);

    // R6: STALL sent on software bit forces halt on
    p_stall_sets_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_sent[k] && !soft_rst) |=> halt_q[k]);
  end

endmodule

// File: rtl/ep_hs_select.sv
module ep_hs_select
  import ep_halt_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_vld,
  input  logic [IDX_W-1:0]  tok_ep,
  input  logic              data_ready,
  input  logic [NUM_EP-1:0] sw_q,
  input  logic [NUM_EP-1:0] halt_q,
  output logic [NUM_EP-1:0] stall_sent,
  output logic              hs_vld,
  output hs_code_e          hs_code
);

  logic [NUM_EP-1:0] tok_hit;    // one-hot addressed endpoint, zero when out of range
  logic              tok_stall;  // named event: addressed endpoint is stalled

  for (genvar k = 0; k < NUM_EP; k++) begin : g_hit
    assign tok_hit[k] = tok_vld && (tok_ep == IDX_W'(k));
  end

  assign tok_stall  = |(tok_hit & (sw_q | halt_q));
  assign stall_sent = tok_hit & sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_vld  <= 1'b0;
      hs_code <= HS_ACK;
    end else begin
      hs_vld <= tok_vld;
      if (tok_vld) hs_code <= hs_pick(tok_stall, data_ready);
    end
  end

  // R4: stalled endpoint answers STALL one cycle later
  p_stall_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_stall) |=> (hs_vld && hs_code == HS_STALL));

  // R4: running endpoint answers ACK/NAK by readiness
  p_normal_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && !tok_stall) |=> (hs_vld && hs_code == (data_ready ? HS_ACK : HS_NAK)));

  // R4: no handshake without a token
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_vld |=> !hs_vld);

  // R10: token ids beyond the endpoint count never hit
  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tok_ep) >= NUM_EP) |-> (tok_hit == '0));

endmodule

// File: rtl/ep_halt_ctrl.sv
module ep_halt_ctrl
  import ep_halt_pkg::*;
#(
  parameter int NUM_EP  = 6,
  parameter int REG_W   = 8,
  parameter int BIT_OFS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             auto_clr_en,
  input  logic             cpu_wr,
  input  logic [REG_W-1:0] cpu_wdata,
  input  logic             cpu_rd,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             host_vld,
  input  logic             host_set,
  input  logic [2:0]       host_ep,
  input  logic             tok_vld,
  input  logic [2:0]       tok_ep,
  input  logic             data_ready,
  output logic             hs_vld,
  output logic [1:0]       hs_code
);

  localparam int IDX_W = 3;
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'(((1 << NUM_EP) - 1) << BIT_OFS);

  logic [NUM_EP-1:0] sw_q;
  logic [NUM_EP-1:0] halt_q;
  logic [NUM_EP-1:0] stall_sent;
  logic [NUM_EP-1:0] wr_bits;
  logic              wr_rsvd_touch;  // named event: write hits a reserved position
  hs_code_e          hs_code_e_q;

  assign wr_bits       = cpu_wdata[BIT_OFS +: NUM_EP];
  assign wr_rsvd_touch = cpu_wr && |(cpu_wdata & ~FIELD_MASK);

  always_comb begin
    cpu_rdata = '0;
    cpu_rdata[BIT_OFS +: NUM_EP] = sw_q;
  end

  ep_sw_stall_reg #(.NUM_EP(NUM_EP)) u_sw (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .auto_clr_en(auto_clr_en),
    .wr_en(cpu_wr), .wr_bits(wr_bits), .rd_en(cpu_rd),
    .stall_sent(stall_sent), .sw_q(sw_q)
  );

  ep_halt_track #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_halt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_vld(host_vld), .host_set(host_set), .host_ep(host_ep),
    .sw_q(sw_q), .stall_sent(stall_sent), .halt_q(halt_q)
  );

  ep_hs_select #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_ep(tok_ep),
    .data_ready(data_ready), .sw_q(sw_q), .halt_q(halt_q),
    .stall_sent(stall_sent), .hs_vld(hs_vld), .hs_code(hs_code_e_q)
  );

  assign hs_code = hs_code_e_q;

  // R2: reserved positions read zero on any read
  p_reserved_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |-> ((cpu_rdata & ~FIELD_MASK) == '0));

  // R2: a write touching reserved bits leaves them reading zero
  p_reserved_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsvd_touch |=> ((cpu_rdata & ~FIELD_MASK) == '0));

endmodule

// File: tb/ep_halt_ctrl_bench.sv
module ep_halt_ctrl_bench;

  localparam int CLK_P = 10;
  localparam int NEP   = 6;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, auto_clr_en;
  logic       cpu_wr, cpu_rd;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       host_vld, host_set;
  logic [2:0] host_ep, tok_ep;
  logic       tok_vld, data_ready;
  logic       hs_vld;
  logic [1:0] hs_code;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model
  bit [NEP-1:0] sw_m, halt_m, arm_m;
  bit           auto_m;

  always #(CLK_P/2) clk = ~clk;

  ep_halt_ctrl u_ep_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .auto_clr_en(auto_clr_en),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .host_vld(host_vld), .host_set(host_set), .host_ep(host_ep),
    .tok_vld(tok_vld), .tok_ep(tok_ep), .data_ready(data_ready),
    .hs_vld(hs_vld), .hs_code(hs_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg();
    return {1'b0, sw_m, 1'b0};
  endfunction

  task automatic rd(input string req);
    @(negedge clk);
    cpu_rd = 1'b1;
    #1;
    check(cpu_rdata == exp_reg(), req, cpu_rdata, exp_reg());
    for (int k = 0; k < NEP; k++) if (!sw_m[k]) arm_m[k] = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0;
    for (int k = 0; k < NEP; k++) begin
      if (!auto_m) sw_m[k] = v[k+1];
      else if (v[k+1] && arm_m[k]) sw_m[k] = 1'b1;
    end
    arm_m = '0;
  endtask

  task automatic host(input bit set, input int ep);
    @(negedge clk);
    host_vld = 1'b1; host_set = set; host_ep = ep[2:0];
    @(negedge clk);
    host_vld = 1'b0;
    if (ep < NEP) halt_m[ep] = set ? 1'b1 : sw_m[ep];
  endtask

  function automatic logic [1:0] exp_hs(input int ep, input bit rdy);
    if (ep < NEP && (sw_m[ep] || halt_m[ep])) return 2'b10;
    return rdy ? 2'b00 : 2'b01;
  endfunction

  task automatic tok(input int ep, input bit rdy, input string req);
    logic [1:0] e;
    e = exp_hs(ep, rdy);
    @(negedge clk);
    tok_vld = 1'b1; tok_ep = ep[2:0]; data_ready = rdy;
    @(negedge clk);
    tok_vld = 1'b0;
    check(hs_vld == 1'b1 && hs_code == e, req, {hs_vld, hs_code}, {1'b1, e});
    if (ep < NEP && sw_m[ep]) begin
      halt_m[ep] = 1'b1;
      if (auto_m) sw_m[ep] = 1'b0;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; auto_clr_en = 1'b0; auto_m = 1'b0;
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0;
    host_vld = 1'b0; host_set = 1'b0; host_ep = '0;
    tok_vld = 1'b0; tok_ep = '0; data_ready = 1'b0;
    sw_m = '0; halt_m = '0; arm_m = '0;
    repeat (3) @(negedge clk);
    check(hs_vld == 1'b0, "R1", hs_vld, 0);
    rst_n = 1'b1;

    // R1 reset state; R4/R10 normal answers on every endpoint id
    rd("R1");
    for (int e = 0; e < 8; e++) tok(e, e[0], "R1_R4_R10");
    @(negedge clk);
    check(hs_vld == 1'b0, "R4 idle", hs_vld, 0);

    // R2/R3 exhaustive direct-mode write/readback
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      rd("R2_R3");
    end
    wr(8'h00);
    rd("R3");

    // R4/R5/R6 per endpoint orderings
    for (int k = 0; k < NEP; k++) begin
      wr(8'(1 << (k + 1)));
      tok(k, 1'b1, "R4 sw stall");
      wr(8'h00);
      tok(k, 1'b0, "R6 halt kept");
      host(1'b0, k);
      tok(k, 1'b1, "R5 released");
      host(1'b1, k);
      tok(k, 1'b0, "R5 set feature");
      host(1'b0, k);
      tok(k, 1'b0, "R5 clear feature");
    end

    // R7 ClearFeature blocked while software bit set, incl. same cycle as token
    for (int k = 0; k < NEP; k++) begin
      wr(8'(1 << (k + 1)));
      host(1'b0, k);
      wr(8'h00);
      tok(k, 1'b1, "R7 blocked clear");
      host(1'b0, k);
      tok(k, 1'b1, "R7 later release");
      wr(8'(1 << (k + 1)));
      @(negedge clk);
      tok_vld = 1'b1; tok_ep = k[2:0]; data_ready = 1'b1;
      host_vld = 1'b1; host_set = 1'b0; host_ep = k[2:0];
      @(negedge clk);
      tok_vld = 1'b0; host_vld = 1'b0;
      check(hs_code == 2'b10, "R7 same-cycle stall", hs_code, 2'b10);
      halt_m[k] = 1'b1;
      wr(8'h00);
      tok(k, 1'b1, "R7 same-cycle halt kept");
      host(1'b0, k);
      tok(k, 1'b1, "R7 final release");
    end

    // R10 out-of-range host requests change nothing
    for (int e = NEP; e < 8; e++) begin
      host(1'b1, e);
      for (int t = 0; t < 8; t++) tok(t, 1'b1, "R10");
      rd("R10");
    end

    // R8/R9 auto-clear mode
    @(negedge clk);
    auto_clr_en = 1'b1; auto_m = 1'b1;
    for (int k = 0; k < NEP; k++) begin
      wr(8'h00);                        // disarm
      wr(8'(1 << (k + 1)));             // unarmed write ignored
      rd("R9 unarmed");
      wr(8'(1 << (k + 1)));             // armed write takes
      rd("R9 armed");
      wr(8'h00);                        // zero write ignored
      rd("R9 zero ignored");
      tok(k, 1'b0, "R8 stall");
      rd("R8 auto cleared");
      tok(k, 1'b0, "R8 halt kept");
      host(1'b0, k);
      tok(k, 1'b0, "R8 released");
    end

    // R1 function-level reset
    @(negedge clk);
    auto_clr_en = 1'b0; auto_m = 1'b0;
    wr(8'h7E);
    host(1'b1, 0);
    for (int k = 0; k < NEP; k++) tok(k, 1'b1, "R4");
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    sw_m = '0; halt_m = '0; arm_m = '0;
    rd("R1 soft reset");
    for (int k = 0; k < NEP; k++) tok(k, 1'b1, "R1 soft reset");

    finish_up();
  end

endmodule